// File: doc/BRIEF.md
# Growing-Dwell Staircase Counter

This block is a free-running counter whose output climbs one step at a time. It holds each output value longer than the one before. Value k stays on the output for 2k+3 consecutive clock samples, so the gap between steps widens by two cycles at every step. The output after n counting edges is the integer square root of n+1, less one. The block can stand in as a cheap square-root-of-time ramp, or as a slowly decelerating pacing signal.

There is no load and no enable. A synchronous active-high reset starts the ramp from zero. The output is a register of parameter width. Once it reaches its all-ones value it stays there, and the internal dwell counting stops. Two registers carry the state: a dwell counter that counts the cycles spent at the current value, and the threshold that counter is compared against. The threshold starts at two and grows by two on every step. Both registers, and the output register, also carry power-up initial values.

Top module: `dwell_staircase`

## Requirements
- R1: A clock edge with `rst` high sets `level` to 0. The value is visible on the following sample.
- R2: Without reset, `level` changes only by +1 from one sample to the next.
- R3: Below saturation, value k is held for exactly 2k+3 consecutive samples before the next step.
- R4: With e counting the non-reset edges since the last reset edge (e = 0 on the sample right after it), `level` equals floor(sqrt(e+1)) - 1 until saturation.
- R5: When `level` reaches 2^LEVEL_W - 1 it holds that value indefinitely and never wraps to 0.
- R6: A reset applied in the middle of a dwell or at saturation restarts the sequence exactly as it runs from power-up reset.
- R7: The first three samples after reset read 0, and the next five read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| level | output | LEVEL_W | Registered staircase value |

## Verification
The bench builds the block with LEVEL_W = 3, so saturation at 7 arrives after 63 counting edges. One run therefore covers every step, every hold length from 3 through 15, and the held saturated value. Further sweeps cover a reset during saturation and a reset in the middle of the dwell at level 4. Each sample is compared against an integer square root computed in the bench.

// File: rtl/staircase_pkg.sv
package staircase_pkg;
  // Threshold for value 0: dwell counts 0..2, giving three samples.
  localparam int unsigned FIRST_LIMIT = 2;
  // Extra samples added to each successive hold.
  localparam int unsigned DWELL_GROWTH = 2;
endpackage

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int unsigned LIM_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  output logic step_o
);
  import staircase_pkg::*;

  logic [LIM_W-1:0] dwell_q = '0;
  logic [LIM_W-1:0] limit_q = LIM_W'(FIRST_LIMIT);

  assign step_o = !hold_i && (dwell_q == limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_q <= '0;
      limit_q <= LIM_W'(FIRST_LIMIT);
    end else if (hold_i) begin
      dwell_q <= dwell_q;
      limit_q <= limit_q;
    end else if (step_o) begin
      dwell_q <= '0;
      limit_q <= limit_q + LIM_W'(DWELL_GROWTH);
    end else begin
      dwell_q <= dwell_q + 1'b1;
    end
  end
endmodule

// File: rtl/level_stepper.sv
module level_stepper #(
  parameter int unsigned LEVEL_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic               at_max_o
);
  localparam logic [LEVEL_W-1:0] TOP = '1;

  logic [LEVEL_W-1:0] level_q = '0;

  assign level_o  = level_q;
  assign at_max_o = (level_q == TOP);

  always_ff @(posedge clk) begin
    if (rst)
      level_q <= '0;
    else if (step_i && !at_max_o)
      level_q <= level_q + 1'b1;
  end
endmodule

// File: rtl/dwell_staircase.sv
module dwell_staircase #(
  parameter int unsigned LEVEL_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  output logic [LEVEL_W-1:0] level
);
  // Largest threshold is 2*(2^W-1)+2 = 2^(W+1), which needs W+2 bits.
  localparam int unsigned LIM_W = LEVEL_W + 2;

  logic step;
  logic at_max;

  dwell_timer #(.LIM_W(LIM_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .hold_i (at_max),
    .step_o (step)
  );

  level_stepper #(.LEVEL_W(LEVEL_W)) u_stepper (
    .clk      (clk),
    .rst      (rst),
    .step_i   (step),
    .level_o  (level),
    .at_max_o (at_max)
  );
endmodule

// File: rtl/dwell_staircase_chk.sv
module dwell_staircase_chk #(
  parameter int unsigned LEVEL_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [LEVEL_W-1:0] level,
  input logic               step
);
  localparam logic [LEVEL_W-1:0] TOP = '1;

  // Set once a reset edge has been seen, so that level holds a known value.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> level == '0);

  p_step_advances_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && step && level != TOP) |=> level == $past(level) + 1'b1);

  p_hold_between_steps_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && !step) |=> $stable(level));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && level == TOP) |=> level == TOP);
endmodule

bind dwell_staircase dwell_staircase_chk #(.LEVEL_W(LEVEL_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .level (level),
  .step  (step)
);

// File: tb/dwell_staircase_test.sv
`timescale 1ns/1ps
module dwell_staircase_test;
  localparam int W = 3;
  localparam int TOPV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] level;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dwell_staircase #(.LEVEL_W(W)) uut (.clk(clk), .rst(rst), .level(level));

  function automatic int isqrt(input int v);
    int r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  function automatic int expect_at(input int e);
    int x = isqrt(e + 1) - 1;
    return (x > TOPV) ? TOPV : x;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Starts on the sample right after a reset edge (e = 0), with rst already low.
  task automatic sweep(input int last_e, input string tag);
    int prev = int'(level);
    int run = 1;
    check({tag, " e=0"}, int'(level), 0);
    for (int e = 1; e <= last_e; e++) begin
      @(negedge clk);
      if (e < 8) check("R7 early values", int'(level), expect_at(e));
      check({tag, " R4 isqrt"}, int'(level), expect_at(e));
      if (expect_at(e) == TOPV && e > 63) check("R5 saturated hold", int'(level), TOPV);
      if (int'(level) == prev) run++;
      else begin
        check("R2 step of one", int'(level), prev + 1);
        check("R3 hold length", run, 2 * prev + 3);
        prev = int'(level);
        run = 1;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset value", int'(level), 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", int'(level), 0);
    sweep(120, "R4");
    do_reset();
    sweep(30, "R6 after saturated reset");
    do_reset();
    sweep(20, "R6 after mid-dwell reset");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule